// File: doc/BRIEF.md
# Mode-Dependent Line and Field Sync Generator

This block derives a line sync and a field sync, both active low, from a single pixel clock for a sensor readout chain. Line length and field length both depend on a three-bit drive mode and a one-bit pattern select. The pattern select chooses between a 60-field-style timing and a 50-field-style timing. Each field holds a whole number of full lines followed by one shorter closing line. In one autofocus mode the length of that closing line alternates from field to field.

The block also reports the pixel position within the current line, the line index within the field and a field parity bit. Downstream pulse tables decode these values. Mode and pattern are taken in only at the start of a field, so a field never changes timing part way through. A select input hands both sync outputs over to external line and field syncs. In that case the counters realign to the falling edges of those external syncs.

Top module: `field_sync_gen`

## Requirements
- R1: While reset is held low and in the first cycle after it is released, pix_o and line_o are 0, parity_o is 0, and hd_n_o and vd_n_o are low. The first field after reset uses draft timing with the 60-field pattern, whatever mode_i and pal_i are.
- R2: Mode codes 001, 010 and 011 use lines of LEN_FRAME clocks. Mode code 000 (draft) and codes 1x0/1x1 (autofocus) use lines of LEN_SLOW clocks.
- R3: hd_n_o is low for the first HD_LEN clocks of every line, the closing short line included, and high for the rest of the line.
- R4: A field is N full lines followed by one closing line of P clocks. The line index runs 0..N and the pixel index restarts at 0 on each line. Both return to 0 together at the field boundary. N and P are chosen by mode and pal_i (0 selects the 60-field pattern): 000 → DRF_N/DRF_P, 001..011 → FRM, 10x → AF1, 11x → AF2.
- R5: In mode 10x with pal_i = 0, the closing line is AF1_N_PART_A clocks in fields with parity 0 and AF1_N_PART_B clocks in fields with parity 1.
- R6: vd_n_o is low for exactly the first full line of each field (line index 0).
- R7: parity_o toggles at every field start and changes at no other time.
- R8: mode_i and pal_i are sampled only at a field start. A change in the middle of a field leaves the length of that field unchanged and takes effect in the next field.
- R9: With ext_sel_i high, hd_n_o and vd_n_o equal ext_hd_n_i and ext_vd_n_i in the same cycle.
- R10: With ext_sel_i high, a falling ext_hd_n_i sets pix_o to 0 and advances line_o by one in the next cycle. A falling ext_vd_n_i sets line_o to 0, toggles parity_o and samples mode_i and pal_i. Otherwise pix_o counts up by one each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Drive mode code |
| pal_i | input | 1 | Pattern select, 1 selects 50-field-style timing |
| ext_sel_i | input | 1 | Use external syncs |
| ext_hd_n_i | input | 1 | External line sync, active low |
| ext_vd_n_i | input | 1 | External field sync, active low |
| hd_n_o | output | 1 | Line sync, active low |
| vd_n_o | output | 1 | Field sync, active low |
| pix_o | output | PIX_W | Pixel index within the line |
| line_o | output | LINE_W | Line index within the field |
| parity_o | output | 1 | Field parity |

## Verification
The assertions assume that the external syncs are synchronous to clk and hold each level for at least one clock. They also assume that every closing-line length is at least 1 and that the field start is reached under internal timing before the mode latch is judged. The bench drives every input on the falling clock edge, so each change is seen cleanly at the next rising edge. It shrinks the line and field lengths through parameters so that whole fields can be measured, and it keeps every closing line longer than the line sync pulse. This way each line, the short one included, shows a distinct falling edge on the line sync.

// File: rtl/field_sync_gen.sv
module field_sync_gen #(
  parameter int PIX_W        = 12,
  parameter int LINE_W       = 10,
  parameter int LEN_FRAME    = 2544,
  parameter int LEN_SLOW     = 2624,
  parameter int HD_LEN       = 124,
  parameter int FRM_N_LINES  = 885,
  parameter int FRM_N_PART   = 810,
  parameter int FRM_P_LINES  = 884,
  parameter int FRM_P_PART   = 1104,
  parameter int DRF_N_LINES  = 285,
  parameter int DRF_N_PART   = 1455,
  parameter int DRF_P_LINES  = 342,
  parameter int DRF_P_PART   = 2592,
  parameter int AF1_N_LINES  = 142,
  parameter int AF1_N_PART_A = 1384,
  parameter int AF1_N_PART_B = 1383,
  parameter int AF1_P_LINES  = 171,
  parameter int AF1_P_PART   = 1296,
  parameter int AF2_N_LINES  = 71,
  parameter int AF2_N_PART   = 1384,
  parameter int AF2_P_LINES  = 85,
  parameter int AF2_P_PART   = 1960
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              pal_i,
  input  logic              ext_sel_i,
  input  logic              ext_hd_n_i,
  input  logic              ext_vd_n_i,
  output logic              hd_n_o,
  output logic              vd_n_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic [LINE_W-1:0] line_o,
  output logic              parity_o
);

  logic [2:0]        mode_q;
  logic              pal_q, par_q, ehd_q, evd_q;
  logic [PIX_W-1:0]  pix_q, len, part;
  logic [LINE_W-1:0] line_q, nfull;
  logic              is_frame, line_end, field_end, ehd_fall, evd_fall;

  assign is_frame = ~mode_q[2] & (|mode_q[1:0]);
  assign len      = is_frame ? PIX_W'(LEN_FRAME) : PIX_W'(LEN_SLOW);

  always_comb begin
    if (mode_q[2] & mode_q[1]) begin
      nfull = pal_q ? LINE_W'(AF2_P_LINES) : LINE_W'(AF2_N_LINES);
      part  = pal_q ? PIX_W'(AF2_P_PART)   : PIX_W'(AF2_N_PART);
    end else if (mode_q[2]) begin
      nfull = pal_q ? LINE_W'(AF1_P_LINES) : LINE_W'(AF1_N_LINES);
      part  = pal_q ? PIX_W'(AF1_P_PART)
                    : (par_q ? PIX_W'(AF1_N_PART_B) : PIX_W'(AF1_N_PART_A));
    end else if (is_frame) begin
      nfull = pal_q ? LINE_W'(FRM_P_LINES) : LINE_W'(FRM_N_LINES);
      part  = pal_q ? PIX_W'(FRM_P_PART)   : PIX_W'(FRM_N_PART);
    end else begin
      nfull = pal_q ? LINE_W'(DRF_P_LINES) : LINE_W'(DRF_N_LINES);
      part  = pal_q ? PIX_W'(DRF_P_PART)   : PIX_W'(DRF_N_PART);
    end
  end

  assign line_end  = (line_q <  nfull) && (pix_q >= len  - 1'b1);
  assign field_end = (line_q >= nfull) && (pix_q >= part - 1'b1);
  assign ehd_fall  = ehd_q & ~ext_hd_n_i;
  assign evd_fall  = evd_q & ~ext_vd_n_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      pal_q  <= 1'b0;
      par_q  <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
      ehd_q  <= 1'b1;
      evd_q  <= 1'b1;
    end else begin
      ehd_q <= ext_hd_n_i;
      evd_q <= ext_vd_n_i;
      if (ext_sel_i) begin
        if (ehd_fall)        pix_q <= '0;
        else if (~&pix_q)    pix_q <= pix_q + 1'b1;
        if (evd_fall) begin
          line_q <= '0;
          par_q  <= ~par_q;
          mode_q <= mode_i;
          pal_q  <= pal_i;
        end else if (ehd_fall) begin
          line_q <= line_q + 1'b1;
        end
      end else if (field_end) begin
        pix_q  <= '0;
        line_q <= '0;
        par_q  <= ~par_q;
        mode_q <= mode_i;
        pal_q  <= pal_i;
      end else if (line_end) begin
        pix_q  <= '0;
        line_q <= line_q + 1'b1;
      end else begin
        pix_q <= pix_q + 1'b1;
      end
    end
  end

  assign hd_n_o   = ext_sel_i ? ext_hd_n_i : ~(pix_q < PIX_W'(HD_LEN));
  assign vd_n_o   = ext_sel_i ? ext_vd_n_i : (line_q != '0);
  assign pix_o    = pix_q;
  assign line_o   = line_q;
  assign parity_o = par_q;

  // R4
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel_i && $past(!ext_sel_i) && line_q == '0 && $past(line_q) != '0)
      |-> pix_q == '0);

  // R7
  parity_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_q != $past(par_q)) |-> line_q == '0);

  // R8
  cfg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel_i && $past(!ext_sel_i) &&
     (mode_q != $past(mode_q) || pal_q != $past(pal_q)))
      |-> (line_q == '0 && pix_q == '0));

  // R10
  ext_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel_i && $past(ext_sel_i) && $past(ehd_fall)) |-> pix_q == '0);

endmodule

// File: tb/tb_field_sync_gen.sv
module tb_field_sync_gen;
  localparam int PERIOD = 10;
  localparam int LF = 20, LS = 24, HDL = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode_i = 3'b001;
  logic       pal_i = 1'b1, ext_sel_i = 1'b0, ext_hd_n_i = 1'b1, ext_vd_n_i = 1'b1;
  logic       hd_n_o, vd_n_o, parity_o;
  logic [11:0] pix_o;
  logic [9:0]  line_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  field_sync_gen #(
    .LEN_FRAME(LF), .LEN_SLOW(LS), .HD_LEN(HDL),
    .FRM_N_LINES(5), .FRM_N_PART(7), .FRM_P_LINES(4), .FRM_P_PART(11),
    .DRF_N_LINES(3), .DRF_N_PART(9), .DRF_P_LINES(4), .DRF_P_PART(13),
    .AF1_N_LINES(2), .AF1_N_PART_A(10), .AF1_N_PART_B(9),
    .AF1_P_LINES(3), .AF1_P_PART(6),
    .AF2_N_LINES(2), .AF2_N_PART(5), .AF2_P_LINES(1), .AF2_P_PART(17)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pal_i(pal_i),
    .ext_sel_i(ext_sel_i), .ext_hd_n_i(ext_hd_n_i), .ext_vd_n_i(ext_vd_n_i),
    .hd_n_o(hd_n_o), .vd_n_o(vd_n_o), .pix_o(pix_o), .line_o(line_o),
    .parity_o(parity_o)
  );

  // mode, pal, full lines, line length, closing line length
  localparam int VEC [0:8][0:4] = '{
    '{0, 0, 3, LS, 9},  '{0, 1, 4, LS, 13},
    '{1, 0, 5, LF, 7},  '{2, 1, 4, LF, 11},
    '{3, 0, 5, LF, 7},  '{4, 1, 3, LS, 6},
    '{6, 0, 2, LS, 5},  '{7, 1, 1, LS, 17},
    '{5, 1, 3, LS, 6}
  };

  task automatic chk(string msg, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic wait_vd_fall;
    logic p;
    p = vd_n_o;
    @(negedge clk);
    while (!(p && !vd_n_o)) begin
      p = vd_n_o;
      @(negedge clk);
    end
  endtask

  // Starts on the first cycle of a field, returns on the first cycle of the next
  task automatic measure(output int flen, output int hds, output int llen,
                         output int vdw, output int hdw, output int maxl, output int par);
    logic ph, pv;
    flen = 1; hds = 1; llen = 0;
    vdw = vd_n_o ? 0 : 1; hdw = hd_n_o ? 0 : 1;
    maxl = int'(line_o); par = int'(parity_o);
    ph = hd_n_o; pv = vd_n_o;
    forever begin
      @(negedge clk);
      if (pv && !vd_n_o) break;
      flen++;
      if (ph && !hd_n_o) begin
        hds++;
        if (hds == 2) llen = flen - 1;
      end
      if (!vd_n_o) vdw++;
      if (!hd_n_o && hds == 1) hdw++;
      if (int'(line_o) > maxl) maxl = int'(line_o);
      ph = hd_n_o; pv = vd_n_o;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int fl, hc, ll, vw, hw, ml, pa, pb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, first field is draft 60-field style despite inputs
    chk("R1 pix", int'(pix_o), 0);
    chk("R1 line", int'(line_o), 0);
    chk("R1 parity", int'(parity_o), 0);
    chk("R1 hd_n", int'(hd_n_o), 0);
    chk("R1 vd_n", int'(vd_n_o), 0);
    measure(fl, hc, ll, vw, hw, ml, pa);
    chk("R1 first field length", fl, 3*LS + 9);

    // R2 R3 R4 R6 table walk
    for (int i = 0; i < 9; i++) begin
      mode_i = 3'(VEC[i][0]);
      pal_i  = VEC[i][1][0];
      wait_vd_fall;
      measure(fl, hc, ll, vw, hw, ml, pa);
      chk($sformatf("R4 field length v%0d", i), fl, VEC[i][2]*VEC[i][3] + VEC[i][4]);
      chk($sformatf("R3 hd falls v%0d", i), hc, VEC[i][2] + 1);
      chk($sformatf("R2 line length v%0d", i), ll, VEC[i][3]);
      chk($sformatf("R6 vd width v%0d", i), vw, VEC[i][3]);
      chk($sformatf("R3 hd width v%0d", i), hw, HDL);
      chk($sformatf("R4 last line index v%0d", i), ml, VEC[i][2]);
    end

    // R5 R7 alternating closing line
    mode_i = 3'b100; pal_i = 1'b0;
    wait_vd_fall;
    measure(fl, hc, ll, vw, hw, ml, pa);
    measure(ll, hc, vw, hw, ml, ml, pb);
    chk("R7 parity toggles", pb, 1 - pa);
    chk("R5 field length A/B", fl, 2*LS + (pa == 0 ? 10 : 9));
    chk("R5 field length B/A", ll, 2*LS + (pb == 0 ? 10 : 9));

    // R8 mid-field change
    mode_i = 3'b011; pal_i = 1'b0;
    wait_vd_fall;
    mode_i = 3'b111; pal_i = 1'b1;
    measure(fl, hc, ll, vw, hw, ml, pa);
    chk("R8 current field unchanged", fl, 5*LF + 7);
    measure(fl, hc, ll, vw, hw, ml, pa);
    chk("R8 next field new config", fl, 1*LS + 17);

    // R9 R10 external sync
    ext_sel_i = 1'b1;
    #1;
    chk("R9 hd pass high", int'(hd_n_o), 1);
    chk("R9 vd pass high", int'(vd_n_o), 1);
    @(negedge clk);
    pa = int'(parity_o);
    ext_hd_n_i = 1'b0; ext_vd_n_i = 1'b0;
    #1;
    chk("R9 hd pass low", int'(hd_n_o), 0);
    chk("R9 vd pass low", int'(vd_n_o), 0);
    @(negedge clk);
    chk("R10 pix realign", int'(pix_o), 0);
    chk("R10 line realign", int'(line_o), 0);
    chk("R10 parity toggle", int'(parity_o), 1 - pa);
    ext_hd_n_i = 1'b1; ext_vd_n_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 pix counts", int'(pix_o), 3);
    ext_hd_n_i = 1'b0;
    @(negedge clk);
    chk("R10 pix on hd fall", int'(pix_o), 0);
    chk("R10 line step", int'(line_o), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule